// File: doc/BRIEF.md
# Sector Write-Protect Unlock Sequencer

This block sits beside a word-wide memory access controller and watches every completed bus access, presented as a one-cycle strobe with a direction bit, a 17-bit word address and the low byte of the data bus. It holds an 8-bit protection mask. Each mask bit guards one 16K-word sector of the 128K-word address space, and the mask gates array writes in the controller.

The mask can only be changed by a fixed ten-access unlock protocol. Six reads at specific addresses come first. Then come a write carrying the new mask, a write carrying the exact bitwise complement of that mask, a write whose data is ignored, and a closing read at address zero. An access that does not match the expected step ends the attempt and leaves the mask untouched. The two mask-carrying writes are flagged to the controller so that they never reach the array. The reset value of the mask stands in for a nonvolatile setting.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset `prot_mask` is 00h (every sector writable), and `wp_updated` and `suppress_array_write` are low.
- R2: The ten steps in order are: reads at 12555h, 1DAAAh, 01333h, 0ECCCh, 000FFh and 1FF00h; a write at 1DAAAh; a write at 0ECCCh; a write at 0FF00h; and a read at 00000h. `acc_write`=1 marks a write. When all ten steps complete, `prot_mask` takes the low data byte of the write at 1DAAAh. It is visible from the clock edge that samples the final read, and `wp_updated` is high for exactly that one cycle.
- R3: `prot_mask` does not change before the final read at 00000h is sampled, even after a correct complement write.
- R4: `suppress_array_write` is high, in the same cycle as the strobe, for the write at 1DAAAh and the write at 0ECCCh when each arrives at its expected step. This holds even when the complement is wrong. It is low for every other access, including writes to those addresses outside the sequence.
- R5: If the low byte of the write at 0ECCCh is not the bitwise complement of the mask byte, the attempt aborts, and completing the remaining steps afterwards leaves `prot_mask` unchanged.
- R6: An access with a wrong address or direction, including a seventh read where the mask write is expected, restarts detection and prevents any update.
- R7: An access that breaks the sequence and is itself a read at 12555h counts as step one of a new attempt.
- R8: `write_blocked` is high in the same cycle as a strobed write whose sector, given by address bits [16:14], has its mask bit set. It is low for reads and for writes to unprotected sectors.
- R9: Cycles with `acc_valid` low are ignored by the sequencer, whatever the other inputs carry.
- R10: An assertion of reset in the middle of a sequence discards the partial attempt and restores the reset mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One-cycle strobe of a completed access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 17 | Word address of the access |
| acc_data | input | 8 | Low data byte of the access |
| prot_mask | output | 8 | Sector protection mask, bit i guards sector i |
| wp_updated | output | 1 | One-cycle pulse when the mask is committed |
| suppress_array_write | output | 1 | Do not commit this write to the array |
| write_blocked | output | 1 | This write targets a protected sector |

## Verification
On every cycle the assertions check the following. The mask only moves together with the update pulse. The pulse follows a strobed read at address zero and never lasts two cycles. Suppression and blocking only ever accompany strobed writes, and suppression only happens at the two protocol addresses. Whether the committed value is the right one, and whether aborts, restarts, ignored idle cycles and a mid-sequence reset leave the mask as they should, are shown only by the bench's scenarios, which compare the mask against values worked out from the sequence rules.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;
  localparam int ADDR_W = 17;
  localparam int STEPS  = 10;
  localparam int STEP_W = $clog2(STEPS);

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [ADDR_W-1:0] waddr_t;

  localparam step_t MASK_STEP  = step_t'(6);
  localparam step_t CHECK_STEP = step_t'(7);
  localparam step_t LAST_STEP  = step_t'(STEPS - 1);

  // Expected word address for each protocol step
  function automatic waddr_t step_addr(input step_t s);
    case (s)
      step_t'(0): step_addr = 17'h12555;
      step_t'(1): step_addr = 17'h1DAAA;
      step_t'(2): step_addr = 17'h01333;
      step_t'(3): step_addr = 17'h0ECCC;
      step_t'(4): step_addr = 17'h000FF;
      step_t'(5): step_addr = 17'h1FF00;
      step_t'(6): step_addr = 17'h1DAAA;
      step_t'(7): step_addr = 17'h0ECCC;
      step_t'(8): step_addr = 17'h0FF00;
      default:    step_addr = 17'h00000;
    endcase
  endfunction

  // Steps 6..8 are writes, all others reads
  function automatic logic step_is_write(input step_t s);
    step_is_write = (s >= MASK_STEP) && (s < LAST_STEP);
  endfunction
endpackage

// File: rtl/wp_step_match.sv
module wp_step_match
  import wp_seq_pkg::*;
(
  input  step_t  step,
  input  logic   acc_write,
  input  waddr_t acc_addr,
  output logic   hit,
  output logic   first_hit
);
  always_comb begin
    hit       = (acc_addr == step_addr(step)) && (acc_write == step_is_write(step));
    first_hit = (acc_addr == step_addr(step_t'(0))) && !acc_write;
  end
endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
  import wp_seq_pkg::*;
#(
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [MASK_W-1:0] acc_data,
  input  logic              hit,
  input  logic              first_hit,
  output step_t             step,
  output logic              commit,
  output logic [MASK_W-1:0] pend_mask,
  output logic              suppress
);
  step_t             step_q, step_d;
  logic [MASK_W-1:0] pend_q;
  logic              pend_en;

  always_comb begin
    step_d  = step_q;
    pend_en = 1'b0;
    if (acc_valid) begin
      if (hit) begin
        if (step_q == CHECK_STEP && acc_data != ~pend_q)
          step_d = step_t'(0);
        else if (step_q == LAST_STEP)
          step_d = step_t'(0);
        else
          step_d = step_t'(step_q + 1'b1);
        pend_en = (step_q == MASK_STEP);
      end else begin
        step_d = first_hit ? step_t'(1) : step_t'(0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= step_t'(0);
    else        step_q <= step_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= acc_data;
  end

  assign step      = step_q;
  assign pend_mask = pend_q;
  assign commit    = acc_valid && hit && (step_q == LAST_STEP);
  assign suppress  = acc_valid && hit && ((step_q == MASK_STEP) || (step_q == CHECK_STEP));
endmodule

// File: rtl/wp_mask_reg.sv
module wp_mask_reg #(
  parameter int              ADDR_W   = 17,
  parameter int              SECTORS  = 8,
  parameter logic [SECTORS-1:0] MASK_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [SECTORS-1:0] new_mask,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic [SECTORS-1:0] prot_mask,
  output logic               wp_updated,
  output logic               write_blocked
);
  localparam int SEC_W = $clog2(SECTORS);

  logic [SEC_W-1:0] sec_idx;
  assign sec_idx = acc_addr[ADDR_W-1 -: SEC_W];

  for (genvar g = 0; g < SECTORS; g++) begin : g_sector
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prot_mask[g] <= MASK_RST[g];
      else if (commit) prot_mask[g] <= new_mask[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_updated <= 1'b0;
    else        wp_updated <= commit;
  end

  assign write_blocked = acc_valid && acc_write && prot_mask[sec_idx];
endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
  import wp_seq_pkg::*;
#(
  parameter int                 SECTORS  = 8,
  parameter logic [SECTORS-1:0] MASK_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [SECTORS-1:0] acc_data,
  output logic [SECTORS-1:0] prot_mask,
  output logic               wp_updated,
  output logic               suppress_array_write,
  output logic               write_blocked
);
  step_t              step;
  logic               hit, first_hit, commit;
  logic [SECTORS-1:0] pend_mask;

  wp_step_match u_match (
    .step      (step),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .hit       (hit),
    .first_hit (first_hit)
  );

  wp_seq_fsm #(.MASK_W(SECTORS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_data  (acc_data),
    .hit       (hit),
    .first_hit (first_hit),
    .step      (step),
    .commit    (commit),
    .pend_mask (pend_mask),
    .suppress  (suppress_array_write)
  );

  wp_mask_reg #(.ADDR_W(ADDR_W), .SECTORS(SECTORS), .MASK_RST(MASK_RST)) u_mask (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit        (commit),
    .new_mask      (pend_mask),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_addr      (acc_addr),
    .prot_mask     (prot_mask),
    .wp_updated    (wp_updated),
    .write_blocked (write_blocked)
  );
endmodule

// File: rtl/wp_unlock_seq_chk.sv
module wp_unlock_seq_chk #(
  parameter int SECTORS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_write,
  input logic [16:0]        acc_addr,
  input logic [SECTORS-1:0] prot_mask,
  input logic               wp_updated,
  input logic               suppress_array_write,
  input logic               write_blocked
);
  // R3: mask moves only together with the update pulse
  assert_mask_needs_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_mask) |-> wp_updated);

  // R2: pulse follows a strobed read at address zero
  assert_pulse_after_final_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wp_updated |-> $past(acc_valid && !acc_write && acc_addr == 17'h00000));

  // R2: pulse lasts one cycle
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wp_updated |=> !wp_updated);

  // R4: suppression only on strobed writes at the two data-step addresses
  assert_suppress_on_protocol_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    suppress_array_write |-> (acc_valid && acc_write &&
      (acc_addr == 17'h1DAAA || acc_addr == 17'h0ECCC)));

  // R8: blocking only on strobed writes
  assert_block_only_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    write_blocked |-> (acc_valid && acc_write));
endmodule

bind wp_unlock_seq wp_unlock_seq_chk #(.SECTORS(SECTORS)) u_chk (
  .clk                  (clk),
  .rst_n                (rst_n),
  .acc_valid            (acc_valid),
  .acc_write            (acc_write),
  .acc_addr             (acc_addr),
  .prot_mask            (prot_mask),
  .wp_updated           (wp_updated),
  .suppress_array_write (suppress_array_write),
  .write_blocked        (write_blocked)
);

// File: tb/wp_unlock_seq_test.sv
module wp_unlock_seq_test;
  localparam int PERIOD = 10;
  localparam int NVEC   = 10;

  // {write, addr[16:0], data[7:0], exp_suppress, exp_updated}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 17'h12555, 8'h00, 1'b0, 1'b0},
    {1'b0, 17'h1DAAA, 8'h00, 1'b0, 1'b0},
    {1'b0, 17'h01333, 8'h00, 1'b0, 1'b0},
    {1'b0, 17'h0ECCC, 8'h00, 1'b0, 1'b0},
    {1'b0, 17'h000FF, 8'h00, 1'b0, 1'b0},
    {1'b0, 17'h1FF00, 8'h00, 1'b0, 1'b0},
    {1'b1, 17'h1DAAA, 8'h18, 1'b1, 1'b0},
    {1'b1, 17'h0ECCC, 8'hE7, 1'b1, 1'b0},
    {1'b1, 17'h0FF00, 8'h5A, 1'b0, 1'b0},
    {1'b0, 17'h00000, 8'h00, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [16:0] acc_addr = '0;
  logic [7:0]  acc_data = '0;
  logic [7:0]  prot_mask;
  logic        wp_updated, suppress_array_write, write_blocked;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  wp_unlock_seq uut (
    .clk                  (clk),
    .rst_n                (rst_n),
    .acc_valid            (acc_valid),
    .acc_write            (acc_write),
    .acc_addr             (acc_addr),
    .acc_data             (acc_data),
    .prot_mask            (prot_mask),
    .wp_updated           (wp_updated),
    .suppress_array_write (suppress_array_write),
    .write_blocked        (write_blocked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] seq_addr(input int i);
    case (i)
      0: seq_addr = 17'h12555; 1: seq_addr = 17'h1DAAA; 2: seq_addr = 17'h01333;
      3: seq_addr = 17'h0ECCC; 4: seq_addr = 17'h000FF; 5: seq_addr = 17'h1FF00;
      6: seq_addr = 17'h1DAAA; 7: seq_addr = 17'h0ECCC; 8: seq_addr = 17'h0FF00;
      default: seq_addr = 17'h00000;
    endcase
  endfunction

  // One strobed access; sup/blk sampled before the edge, upd after it
  task automatic do_acc(input logic w, input logic [16:0] a, input logic [7:0] d,
                        output logic sup, output logic blk, output logic upd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_data = d;
    #1;
    sup = suppress_array_write;
    blk = write_blocked;
    @(negedge clk);
    acc_valid = 1'b0;
    upd = wp_updated;
  endtask

  // Run steps from..9 of the sequence; noise inserts an idle cycle with junk inputs
  task automatic run_seq(input int from, input logic [7:0] m, input logic [7:0] c,
                         input logic noise, output logic upd_last);
    logic s, b, u;
    upd_last = 1'b0;
    for (int i = from; i < 10; i++) begin
      if (noise) begin
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 17'h00000; acc_data = 8'hFF;
      end
      do_acc(i >= 6 && i <= 8, seq_addr(i), (i == 6) ? m : (i == 7) ? c : 8'h00, s, b, u);
      upd_last = u;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic s, b, u;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mask", prot_mask, 8'h00);
    check("R1 upd", wp_updated, 1'b0);
    check("R1 sup", suppress_array_write, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R4 table walk: mask 18h
    for (int i = 0; i < NVEC; i++) begin
      do_acc(VEC[i][27], VEC[i][26:10], VEC[i][9:2], s, b, u);
      check($sformatf("R4 suppress step %0d", i), s, VEC[i][1]);
      check($sformatf("R2 updated step %0d", i), u, VEC[i][0]);
      if (i == 8) check("R3 mask held before final read", prot_mask, 8'h00);
    end
    check("R2 committed mask", prot_mask, 8'h18);
    @(negedge clk);
    check("R2 pulse one cycle", wp_updated, 1'b0);

    // R8 write gating
    do_acc(1'b1, 17'h0C000, 8'h00, s, b, u);
    check("R8 sector3 write blocked", b, 1'b1);
    do_acc(1'b1, 17'h13FFF, 8'h00, s, b, u);
    check("R8 sector4 write blocked", b, 1'b1);
    do_acc(1'b1, 17'h0BFFF, 8'h00, s, b, u);
    check("R8 sector2 write open", b, 1'b0);
    do_acc(1'b0, 17'h0C000, 8'h00, s, b, u);
    check("R8 read not blocked", b, 1'b0);
    // R4 protocol address outside sequence
    do_acc(1'b1, 17'h1DAAA, 8'h00, s, b, u);
    check("R4 stray write not suppressed", s, 1'b0);

    // R5 complement mismatch
    run_seq(0, 8'h81, 8'h7F, 1'b0, u);
    check("R5 no pulse", u, 1'b0);
    check("R5 mask unchanged", prot_mask, 8'h18);

    // R6 out-of-order address at step 3
    for (int i = 0; i < 3; i++) do_acc(1'b0, seq_addr(i), 8'h00, s, b, u);
    do_acc(1'b0, 17'h000FF, 8'h00, s, b, u);
    run_seq(4, 8'h0F, 8'hF0, 1'b0, u);
    check("R6 wrong order no pulse", u, 1'b0);
    check("R6 wrong order mask", prot_mask, 8'h18);
    // R6 seventh read
    for (int i = 0; i < 6; i++) do_acc(1'b0, seq_addr(i), 8'h00, s, b, u);
    do_acc(1'b0, 17'h1DAAA, 8'h00, s, b, u);
    run_seq(6, 8'h0F, 8'hF0, 1'b0, u);
    check("R6 seventh read no pulse", u, 1'b0);
    check("R6 seventh read mask", prot_mask, 8'h18);
    // R6 wrong direction at step 0
    do_acc(1'b1, 17'h12555, 8'h00, s, b, u);
    run_seq(1, 8'h0F, 8'hF0, 1'b0, u);
    check("R6 write at read step mask", prot_mask, 8'h18);

    // R7 break at 12555h restarts as step one
    do_acc(1'b0, 17'h12555, 8'h00, s, b, u);
    do_acc(1'b0, 17'h1DAAA, 8'h00, s, b, u);
    do_acc(1'b0, 17'h12555, 8'h00, s, b, u);
    run_seq(1, 8'h03, 8'hFC, 1'b0, u);
    check("R7 pulse", u, 1'b1);
    check("R7 mask", prot_mask, 8'h03);

    // R9 idle cycles with junk ignored
    run_seq(0, 8'hC0, 8'h3F, 1'b1, u);
    check("R9 pulse with idle gaps", u, 1'b1);
    check("R9 mask", prot_mask, 8'hC0);

    // R10 reset mid sequence
    for (int i = 0; i < 3; i++) do_acc(1'b0, seq_addr(i), 8'h00, s, b, u);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R10 mask restored", prot_mask, 8'h00);
    run_seq(3, 8'hAA, 8'h55, 1'b0, u);
    check("R10 partial discarded", prot_mask, 8'h00);
    check("R10 no pulse", u, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule